// File: doc/BRIEF.md
# Synchronization Event Conditioner

This block takes several raw timing references (a 32 kHz crystal clock, a USB start-of-frame pulse and a general-purpose input pin), picks one of them, and turns its transitions into clean one-cycle SYNC pulses in the local oscillator clock domain. The chosen line is sampled by the oscillator clock, and a 2-of-3 majority vote removes short glitches. One transition direction is then selected as the event, and a power-of-two prescaler thins the events so that the SYNC rate lands near 1 kHz. A USB start-of-frame every 1 ms needs no division. A crystal clock needs a larger ratio.

Software can also request a SYNC directly. The request is taken on its rising edge, which gives the self-clearing behaviour of a one-shot request bit. It bypasses the prescaler and yields exactly one pulse. The output feeds a frequency-error counter elsewhere in the chip.

Top module: `sync_event_shaper`

## Requirements
- R1: `src_sel` picks the source: 00 = crystal line, 01 = start-of-frame line, 10 = pin line, 11 = no source (no hardware events). Lines that are not selected have no effect on `sync_pulse`.
- R2: The selected line is sampled on every clock, and the filtered level is the majority of the last three samples. A high or low excursion lasting one clock changes nothing. A change held for two or more clocks is accepted.
- R3: `pol_fall` = 0 makes a rising filtered transition the event, and `pol_fall` = 1 makes a falling filtered transition the event. The other direction produces no pulse.
- R4: With divide code 000, a selected-line transition set up before clock edge n makes `sync_pulse` high for the cycle after edge n+3.
- R5: `div_code` c (3 bits) gives one pulse per 2^c qualified events (000 = /1 up to 111 = /128). The first pulse comes on the 2^c-th event after reset or after a settings change.
- R6: Any change of `src_sel` or `div_code` clears the prescaler count. An event in the same cycle as the change is dropped.
- R7: A rising edge of `sw_sync_req` gives `sync_pulse` high in the next cycle, whatever the divide code. Holding the request high gives only one pulse.
- R8: Every `sync_pulse` is exactly one cycle wide per originating event, and it comes only from a prescaler wrap or a software request.
- R9: While `rst_n` is low, `sync_pulse` is 0 and the filter, edge and prescaler state are cleared.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Local oscillator clock |
| rst_n | input | 1 | Active-low reset, synchronous to clk |
| src_xtal | input | 1 | 32 kHz crystal clock line |
| src_sof | input | 1 | USB start-of-frame pulse line |
| src_pin | input | 1 | External sync pin line |
| src_sel | input | 2 | Source select (R1 encoding) |
| pol_fall | input | 1 | 0: rising transition is the event, 1: falling transition is the event |
| div_code | input | 3 | Prescaler code, ratio 2^div_code |
| sw_sync_req | input | 1 | Software sync request, taken on its rising edge |
| sync_pulse | output | 1 | One-cycle SYNC pulse |

## Verification
The assertions check several properties on every cycle. Each software request edge and each undivided hardware event is followed by a pulse. Every pulse has a wrap or a request behind it, and the prescaler count stays below the selected ratio. A change in the filtered level is always backed by the selected line's value two cycles earlier. Some behaviour only the bench scenarios can show: the exact number of pulses per burst of source periods at each ratio, the rejection of one-cycle glitches and of unselected lines, and the count clearing on a settings change. These depend on whole sequences of stimulus and not on one-cycle relations.

// File: rtl/sync_cond_pkg.sv
package sync_cond_pkg;
  localparam int SRC_COUNT   = 3;
  localparam int SEL_WIDTH   = 2;
  localparam int DIV_WIDTH   = 3;
  localparam int VOTE_TAPS   = 3;

  // majority of three samples
  function automatic logic vote3(input logic [2:0] s);
    return (s[0] & s[1]) | (s[1] & s[2]) | (s[0] & s[2]);
  endfunction

  // events per output pulse for a divide code
  function automatic int unsigned div_ratio(input int unsigned code);
    return 32'd1 << code;
  endfunction
endpackage

// File: rtl/sync_src_filter.sv
module sync_src_filter
  import sync_cond_pkg::*;
#(
  parameter int SRC_N = SRC_COUNT,
  parameter int SEL_W = SEL_WIDTH,
  parameter int TAPS  = VOTE_TAPS
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SRC_N-1:0] src_vec,
  input  logic [SEL_W-1:0] sel,
  output logic             sel_line,
  output logic             filt_level
);
  logic [TAPS-1:0] smp_q;
  logic            vote;

  always_comb begin
    sel_line = 1'b0;
    for (int i = 0; i < SRC_N; i++) begin
      if (sel == SEL_W'(i)) sel_line = src_vec[i];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) smp_q <= '0;
    else        smp_q <= {smp_q[TAPS-2:0], sel_line};
  end

  generate
    if (TAPS == 3) begin : g_vote3
      assign vote = vote3(smp_q);
    end else begin : g_voten
      assign vote = ($countones(smp_q) > (TAPS / 2));
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) filt_level <= 1'b0;
    else        filt_level <= vote;
  end
endmodule

// File: rtl/sync_edge_pick.sv
module sync_edge_pick (
  input  logic clk,
  input  logic rst_n,
  input  logic filt_level,
  input  logic pol_fall,
  output logic edge_evt
);
  logic level_d;

  always_ff @(posedge clk) begin
    if (!rst_n) level_d <= 1'b0;
    else        level_d <= filt_level;
  end

  assign edge_evt = pol_fall ? (level_d & ~filt_level) : (filt_level & ~level_d);
endmodule

// File: rtl/sync_event_prescaler.sv
module sync_event_prescaler
  import sync_cond_pkg::*;
#(
  parameter int DIV_W = DIV_WIDTH,
  parameter int CNT_W = (1 << DIV_W) - 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             evt,
  input  logic             clear,
  input  logic [DIV_W-1:0] div_code,
  output logic             wrap,
  output logic [CNT_W-1:0] count
);
  logic [CNT_W-1:0] last_cnt;

  assign last_cnt = CNT_W'(div_ratio(32'(div_code)) - 32'd1);
  assign wrap     = evt & ~clear & (count == last_cnt);

  always_ff @(posedge clk) begin
    if (!rst_n)    count <= '0;
    else if (clear) count <= '0;
    else if (wrap)  count <= '0;
    else if (evt)   count <= count + 1'b1;
  end
endmodule

// File: rtl/sync_event_shaper.sv
module sync_event_shaper
  import sync_cond_pkg::*;
#(
  parameter int SEL_W = SEL_WIDTH,
  parameter int DIV_W = DIV_WIDTH,
  parameter int TAPS  = VOTE_TAPS
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             src_xtal,
  input  logic             src_sof,
  input  logic             src_pin,
  input  logic [SEL_W-1:0] src_sel,
  input  logic             pol_fall,
  input  logic [DIV_W-1:0] div_code,
  input  logic             sw_sync_req,
  output logic             sync_pulse
);
  localparam int CNT_W = (1 << DIV_W) - 1;
  localparam int CFG_W = SEL_W + DIV_W;

  logic             sel_line;
  logic             filt_level;
  logic             edge_evt;
  logic             pre_wrap;
  logic [CNT_W-1:0] pre_count;
  logic [CFG_W-1:0] cfg_prev;
  logic             cfg_change;
  logic             sw_prev;
  logic             sw_evt;

  sync_src_filter #(.SRC_N(SRC_COUNT), .SEL_W(SEL_W), .TAPS(TAPS)) u_filter (
    .clk        (clk),
    .rst_n      (rst_n),
    .src_vec    ({src_pin, src_sof, src_xtal}),
    .sel        (src_sel),
    .sel_line   (sel_line),
    .filt_level (filt_level)
  );

  sync_edge_pick u_edge (
    .clk        (clk),
    .rst_n      (rst_n),
    .filt_level (filt_level),
    .pol_fall   (pol_fall),
    .edge_evt   (edge_evt)
  );

  assign cfg_change = ({src_sel, div_code} != cfg_prev);

  sync_event_prescaler #(.DIV_W(DIV_W), .CNT_W(CNT_W)) u_presc (
    .clk      (clk),
    .rst_n    (rst_n),
    .evt      (edge_evt),
    .clear    (cfg_change),
    .div_code (div_code),
    .wrap     (pre_wrap),
    .count    (pre_count)
  );

  assign sw_evt = sw_sync_req & ~sw_prev;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_prev   <= '0;
      sw_prev    <= 1'b0;
      sync_pulse <= 1'b0;
    end else begin
      cfg_prev   <= {src_sel, div_code};
      sw_prev    <= sw_sync_req;
      sync_pulse <= pre_wrap | sw_evt;
    end
  end
endmodule

// File: rtl/sync_cond_checker.sv
module sync_cond_checker
  import sync_cond_pkg::*;
#(
  parameter int DIV_W = DIV_WIDTH,
  parameter int CNT_W = (1 << DIV_W) - 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic [DIV_W-1:0] div_code,
  input logic             sync_pulse,
  input logic             sel_line,
  input logic             filt_level,
  input logic             edge_evt,
  input logic             sw_evt,
  input logic             pre_wrap,
  input logic             cfg_change,
  input logic [CNT_W-1:0] pre_count
);
  // R2: a filtered change is backed by the selected line two cycles back
  assert_filter_backed_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (filt_level != $past(filt_level)) |-> ($past(sel_line, 2) == filt_level));

  // R7: a request edge gives a pulse next cycle
  assert_sw_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    sw_evt |=> sync_pulse);

  // R4: undivided event gives a pulse next cycle
  assert_undivided_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_evt && div_code == '0 && !cfg_change) |=> sync_pulse);

  // R5: count stays below the ratio
  assert_count_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_change |-> (32'(pre_count) < div_ratio(32'(div_code))));

  // R8: every pulse has a cause
  assert_pulse_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
    sync_pulse |-> $past(sw_evt || pre_wrap));

  // R6: no wrap without an event, none during a settings change
  assert_wrap_gated_R6: assert property (@(posedge clk) disable iff (!rst_n)
    pre_wrap |-> (edge_evt && !cfg_change));
endmodule

bind sync_event_shaper sync_cond_checker #(.DIV_W(DIV_W), .CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .div_code   (div_code),
  .sync_pulse (sync_pulse),
  .sel_line   (sel_line),
  .filt_level (filt_level),
  .edge_evt   (edge_evt),
  .sw_evt     (sw_evt),
  .pre_wrap   (pre_wrap),
  .cfg_change (cfg_change),
  .pre_count  (pre_count)
);

// File: tb/tb_sync_event_shaper.sv
module tb_sync_event_shaper;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] lines = 3'b000;
  logic [1:0] src_sel = 2'd0;
  logic       pol_fall = 1'b0;
  logic [2:0] div_code = 3'd0;
  logic       sw_sync_req = 1'b0;
  logic       sync_pulse;

  int n_cmp = 0;
  int n_bad = 0;
  int pulse_cnt = 0;
  int cyc = 0;

  always #2 clk = ~clk;

  sync_event_shaper dut (
    .clk(clk), .rst_n(rst_n),
    .src_xtal(lines[0]), .src_sof(lines[1]), .src_pin(lines[2]),
    .src_sel(src_sel), .pol_fall(pol_fall), .div_code(div_code),
    .sw_sync_req(sw_sync_req), .sync_pulse(sync_pulse)
  );

  always @(negedge clk) begin
    cyc++;
    if (rst_n && sync_pulse) pulse_cnt++;
  end

  typedef struct packed {
    logic [1:0] sel;
    logic       pol;
    logic [2:0] div;
    logic [1:0] line;
    logic [7:0] periods;
    logic [7:0] expn;
  } vec_t;

  localparam int NVEC = 10;
  localparam vec_t TABLE [NVEC] = '{
    '{2'd0, 1'b0, 3'd0, 2'd0, 8'd5,   8'd5},  // R1 crystal
    '{2'd1, 1'b0, 3'd0, 2'd1, 8'd4,   8'd4},  // R1 sof
    '{2'd2, 1'b1, 3'd0, 2'd2, 8'd3,   8'd3},  // R1/R3 pin falling
    '{2'd0, 1'b0, 3'd0, 2'd1, 8'd4,   8'd0},  // R1 unselected line
    '{2'd3, 1'b0, 3'd0, 2'd2, 8'd4,   8'd0},  // R1 code 11 none
    '{2'd1, 1'b0, 3'd1, 2'd1, 8'd5,   8'd2},  // R5 /2
    '{2'd2, 1'b0, 3'd2, 2'd2, 8'd9,   8'd2},  // R5 /4
    '{2'd0, 1'b1, 3'd3, 2'd0, 8'd16,  8'd2},  // R5 /8 falling
    '{2'd1, 1'b0, 3'd7, 2'd1, 8'd128, 8'd1},  // R5 /128
    '{2'd0, 1'b0, 3'd6, 2'd0, 8'd63,  8'd0}   // R5 /64 short
  };

  task automatic check(input int act, input int exp, input string req);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    wait_cyc(3);
    check(int'(sync_pulse), 0, "R9 pulse low in reset");
    rst_n = 1'b1;
  endtask

  task automatic drive_period(input int idx);
    lines[idx] = 1'b1;
    wait_cyc(6);
    lines[idx] = 1'b0;
    wait_cyc(6);
  endtask

  task automatic report();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    wait (cyc > 150000);
    n_bad++;
    $display("FAIL watchdog: actual %0d expected 0 cycles over limit", cyc);
    report();
  end

  initial begin
    // R9: reset state
    wait_cyc(2);
    do_reset();
    wait_cyc(1);
    check(int'(sync_pulse), 0, "R9 pulse low after reset");

    // table walk: R1, R3, R5
    for (int v = 0; v < NVEC; v++) begin
      do_reset();
      src_sel  = TABLE[v].sel;
      pol_fall = TABLE[v].pol;
      div_code = TABLE[v].div;
      wait_cyc(4);
      pulse_cnt = 0;
      for (int p = 0; p < int'(TABLE[v].periods); p++) drive_period(int'(TABLE[v].line));
      wait_cyc(8);
      check(pulse_cnt, int'(TABLE[v].expn), $sformatf("R5/R1 vector %0d", v));
    end

    // R4/R8: latency and width
    do_reset();
    src_sel = 2'd0; pol_fall = 1'b0; div_code = 3'd0;
    wait_cyc(4);
    lines[0] = 1'b1;
    wait_cyc(3);
    check(int'(sync_pulse), 0, "R4 no pulse after edge n+2");
    wait_cyc(1);
    check(int'(sync_pulse), 1, "R4 pulse after edge n+3");
    wait_cyc(1);
    check(int'(sync_pulse), 0, "R8 pulse one cycle wide");
    lines[0] = 1'b0;
    wait_cyc(8);

    // R2: glitch rejection
    pulse_cnt = 0;
    lines[0] = 1'b1; wait_cyc(1); lines[0] = 1'b0;
    wait_cyc(10);
    check(pulse_cnt, 0, "R2 one-cycle high glitch");
    lines[0] = 1'b1; wait_cyc(2); lines[0] = 1'b0;
    wait_cyc(10);
    check(pulse_cnt, 1, "R2 two-cycle pulse accepted");
    lines[0] = 1'b1; wait_cyc(8);
    pulse_cnt = 0;
    lines[0] = 1'b0; wait_cyc(1); lines[0] = 1'b1;
    wait_cyc(10);
    check(pulse_cnt, 0, "R2 one-cycle low dip");
    lines[0] = 1'b0; wait_cyc(8);

    // R3: falling polarity ignores rise
    pol_fall = 1'b1;
    wait_cyc(2);
    pulse_cnt = 0;
    lines[0] = 1'b1; wait_cyc(8);
    check(pulse_cnt, 0, "R3 rise ignored when falling selected");
    lines[0] = 1'b0; wait_cyc(8);
    check(pulse_cnt, 1, "R3 fall counted");
    pol_fall = 1'b0;

    // R6: settings change clears count
    do_reset();
    src_sel = 2'd0; div_code = 3'd2;
    wait_cyc(4);
    pulse_cnt = 0;
    for (int p = 0; p < 3; p++) drive_period(0);
    div_code = 3'd3; wait_cyc(2);
    div_code = 3'd2; wait_cyc(2);
    drive_period(0);
    wait_cyc(4);
    check(pulse_cnt, 0, "R6 count cleared on divider change");
    for (int p = 0; p < 3; p++) drive_period(0);
    wait_cyc(4);
    check(pulse_cnt, 1, "R6 wrap after full ratio");

    // R7: software request bypasses divider, one pulse per edge
    div_code = 3'd7;
    wait_cyc(2);
    pulse_cnt = 0;
    sw_sync_req = 1'b1;
    wait_cyc(1);
    check(int'(sync_pulse), 1, "R7 pulse next cycle");
    wait_cyc(4);
    sw_sync_req = 1'b0;
    wait_cyc(3);
    check(pulse_cnt, 1, "R7 held request gives one pulse");

    report();
  end
endmodule